// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for the instruction currently in the execute stage of a five-stage 64-bit load/store pipeline, where each of its operands should come from. There are three register operands: the first ALU source, the second ALU source, and the tested register. The tested register is the one checked by compare-and-branch-if-zero, or the data register of a store. Each operand can come from the register file, from the result held in the memory stage, or from the result held in the writeback stage. The block compares each operand's register index with the destination index and write enable of the two older in-flight instructions. It returns a two-bit select per operand. A fourth select picks the source of the condition flags for a conditional branch in execute.

The block is purely combinational and holds no state. The datapath muxes, the ALU, the register file and the stall logic live outside it. The last register index, which is all ones, is the constant-zero register. It is never bypassed, whatever an older instruction claims to write to it. A load in the memory stage has no data yet, so it is not a source. The consumer two slots behind a load picks the loaded value up from writeback. Stalling a consumer that sits directly behind a load belongs to the hazard unit.

Top module: `fwd_unit`

## Requirements
- R1: An operand with no matching in-flight writer gets select 00 (register file).
- R2: An operand whose index equals the memory-stage destination, with memory-stage write enable high and the memory-stage instruction not a load, gets select 01 (memory-stage result).
- R3: An operand matched only by a writing writeback-stage instruction gets select 10 (writeback-stage result).
- R4: When the memory and writeback stages both write the operand's register, the younger writer wins: select 01.
- R5: An operand whose index is all ones (the zero register) always gets select 00, even when a writer targets that index.
- R6: A producer whose write enable is low (a store or a branch) never causes a bypass, even when its destination field equals the operand index.
- R7: A load in the memory stage is never selected; a load that has reached writeback is forwarded with select 10.
- R8: The tested-register operand follows the same rules as the ALU operands. Its select depends only on indices and enables, never on the value, zero or nonzero.
- R9: The flag select is 01 when the memory-stage instruction sets flags, otherwise 10 when the writeback-stage instruction sets flags, otherwise 00 (architectural flags).
- R10: No select output ever takes the code 11.
- R11: Each operand's select depends only on its own index; two operands with different indices in the same cycle are resolved independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rn | input | RIDX_W | Index of the first ALU source in execute |
| ex_rm | input | RIDX_W | Index of the second ALU source in execute |
| ex_rt | input | RIDX_W | Index of the tested or store-data register in execute |
| mem_wen | input | 1 | Memory-stage instruction writes the register file |
| mem_dst | input | RIDX_W | Memory-stage destination index |
| mem_is_load | input | 1 | Memory-stage instruction is a load (data not yet available) |
| mem_sets_flags | input | 1 | Memory-stage instruction updates the condition flags |
| wb_wen | input | 1 | Writeback-stage instruction writes the register file |
| wb_dst | input | RIDX_W | Writeback-stage destination index |
| wb_sets_flags | input | 1 | Writeback-stage instruction updates the condition flags |
| sel_rn | output | 2 | Bypass select for the first ALU source |
| sel_rm | output | 2 | Bypass select for the second ALU source |
| sel_rt | output | 2 | Bypass select for the tested register |
| sel_flags | output | 2 | Bypass select for the condition flags |

## Verification
The assertions assume only that every input is at a known level whenever it is evaluated. They make no assumption about which stage combinations a real pipeline issues. That includes a load in the memory stage feeding the next instruction, which a correct pipeline would have stalled. The stimulus uses a three-bit index configuration and covers every pairing of memory and writeback destinations, enables, load flag and source index. It therefore deliberately includes combinations that the stall unit would never let through. This shows the selects stay legal and correctly ordered across the whole input space.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MEM = 2'b01,
    SEL_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_hit.sv
// Decides whether one producer stage can supply one operand.
module fwd_hit #(
  parameter int RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] src_idx,
  input  logic              prod_wen,
  input  logic [RIDX_W-1:0] prod_dst,
  input  logic              prod_ready,
  output logic              hit
);
  localparam logic [RIDX_W-1:0] ZERO_IDX = '1;

  always_comb begin
    hit = prod_wen && prod_ready && (prod_dst == src_idx) && (src_idx != ZERO_IDX);
  end
endmodule

// File: rtl/fwd_prio.sv
// Youngest-first choice between the two producer stages.
module fwd_prio (
  input  logic       young_hit,
  input  logic       old_hit,
  output logic [1:0] sel
);
  import fwd_pkg::*;

  fwd_sel_e pick;

  always_comb begin
    if (young_hit)    pick = SEL_MEM;
    else if (old_hit) pick = SEL_WB;
    else              pick = SEL_RF;
    sel = pick;
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] ex_rn,
  input  logic [RIDX_W-1:0] ex_rm,
  input  logic [RIDX_W-1:0] ex_rt,
  input  logic              mem_wen,
  input  logic [RIDX_W-1:0] mem_dst,
  input  logic              mem_is_load,
  input  logic              mem_sets_flags,
  input  logic              wb_wen,
  input  logic [RIDX_W-1:0] wb_dst,
  input  logic              wb_sets_flags,
  output logic [1:0]        sel_rn,
  output logic [1:0]        sel_rm,
  output logic [1:0]        sel_rt,
  output logic [1:0]        sel_flags
);
  localparam int NSRC = 3;

  logic [RIDX_W-1:0] src [NSRC];
  logic [1:0]        sel [NSRC];
  logic              mem_ready;

  always_comb begin
    src[0]    = ex_rn;
    src[1]    = ex_rm;
    src[2]    = ex_rt;
    mem_ready = !mem_is_load;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic mem_hit;
    logic wb_hit;

    fwd_hit #(.RIDX_W(RIDX_W)) u_mem_hit (
      .src_idx   (src[i]),
      .prod_wen  (mem_wen),
      .prod_dst  (mem_dst),
      .prod_ready(mem_ready),
      .hit       (mem_hit)
    );

    fwd_hit #(.RIDX_W(RIDX_W)) u_wb_hit (
      .src_idx   (src[i]),
      .prod_wen  (wb_wen),
      .prod_dst  (wb_dst),
      .prod_ready(1'b1),
      .hit       (wb_hit)
    );

    fwd_prio u_prio (
      .young_hit(mem_hit),
      .old_hit  (wb_hit),
      .sel      (sel[i])
    );
  end

  fwd_prio u_flag_prio (
    .young_hit(mem_sets_flags),
    .old_hit  (wb_sets_flags),
    .sel      (sel_flags)
  );

  always_comb begin
    sel_rn = sel[0];
    sel_rm = sel[1];
    sel_rt = sel[2];
  end
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int RIDX_W = 5
) (
  input logic [RIDX_W-1:0] ex_rn,
  input logic [RIDX_W-1:0] ex_rm,
  input logic [RIDX_W-1:0] ex_rt,
  input logic              mem_wen,
  input logic [RIDX_W-1:0] mem_dst,
  input logic              mem_is_load,
  input logic              mem_sets_flags,
  input logic              wb_wen,
  input logic [RIDX_W-1:0] wb_dst,
  input logic              wb_sets_flags,
  input logic [1:0]        sel_rn,
  input logic [1:0]        sel_rm,
  input logic [1:0]        sel_rt,
  input logic [1:0]        sel_flags
);
  localparam logic [RIDX_W-1:0] ZERO_IDX = '1;

  logic known;

  always_comb begin
    known = !$isunknown({ex_rn, ex_rm, ex_rt, mem_wen, mem_dst, mem_is_load,
                         mem_sets_flags, wb_wen, wb_dst, wb_sets_flags,
                         sel_rn, sel_rm, sel_rt, sel_flags});
    if (known) begin
      assert_legal_code_R10: assert (sel_rn != 2'b11 && sel_rm != 2'b11 &&
                                     sel_rt != 2'b11 && sel_flags != 2'b11);
      assert_zero_reg_R5: assert ((ex_rn != ZERO_IDX || sel_rn == 2'b00) &&
                                  (ex_rt != ZERO_IDX || sel_rt == 2'b00));
      assert_mem_source_R6: assert (sel_rn != 2'b01 ||
                                    (mem_wen && mem_dst == ex_rn));
      assert_load_not_mem_R7: assert (!mem_is_load ||
                                      (sel_rn != 2'b01 && sel_rm != 2'b01 && sel_rt != 2'b01));
      assert_wb_source_R3: assert (sel_rm != 2'b10 ||
                                   (wb_wen && wb_dst == ex_rm));
      assert_youngest_R4: assert (!(mem_wen && !mem_is_load && wb_wen &&
                                    mem_dst == ex_rt && wb_dst == ex_rt &&
                                    ex_rt != ZERO_IDX) || sel_rt == 2'b01);
      assert_flag_order_R9: assert ((!mem_sets_flags || sel_flags == 2'b01) &&
                                    (mem_sets_flags || !wb_sets_flags || sel_flags == 2'b10) &&
                                    (mem_sets_flags || wb_sets_flags || sel_flags == 2'b00));
    end
  end
endmodule

bind fwd_unit fwd_unit_chk #(.RIDX_W(RIDX_W)) u_chk (.*);

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
  localparam int W = 3;
  localparam logic [W-1:0] ZR = '1;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] ex_rn = '0, ex_rm = '0, ex_rt = '0, mem_dst = '0, wb_dst = '0;
  logic mem_wen = 1'b0, mem_is_load = 1'b0, mem_sets_flags = 1'b0;
  logic wb_wen = 1'b0, wb_sets_flags = 1'b0;
  logic [1:0] sel_rn, sel_rm, sel_rt, sel_flags;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  fwd_unit #(.RIDX_W(W)) u_fwd_unit (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run exceeded %0d cycles", LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [1:0] expect_sel(logic [W-1:0] idx);
    if (idx == ZR) return 2'b00;
    if (mem_wen && !mem_is_load && mem_dst == idx) return 2'b01;
    if (wb_wen && wb_dst == idx) return 2'b10;
    return 2'b00;
  endfunction

  function automatic string tag_for(logic [W-1:0] idx);
    if (idx == ZR) return "R5";
    if (mem_is_load && mem_wen && mem_dst == idx) return "R7";
    if (mem_wen && wb_wen && mem_dst == idx && wb_dst == idx) return "R4";
    if (mem_wen && mem_dst == idx) return "R2";
    if (wb_wen && wb_dst == idx) return "R3";
    if (mem_dst == idx || wb_dst == idx) return "R6";
    return "R1";
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks = checks + 1;
    if (act !== exp || act === 2'b11) begin
      errors = errors + 1;
      $display("FAIL %s: actual %b expected %b (R10 legal code)", req, act, exp);
    end
  endtask

  initial begin
    // Idle inputs: every select at register file (R1)
    @(negedge clk);
    check("R1 idle rn", sel_rn, 2'b00);
    check("R1 idle rt", sel_rt, 2'b00);
    check("R9 idle flags", sel_flags, 2'b00);

    // Sweep of all destinations, enables, load flag and source index.
    // rm and rt use other indices in the same cycle (R11 independence).
    for (int md = 0; md < 8; md++) begin
      for (int wd = 0; wd < 8; wd++) begin
        for (int ctl = 0; ctl < 8; ctl++) begin
          for (int s = 0; s < 8; s++) begin
            mem_dst        = W'(md);
            wb_dst         = W'(wd);
            mem_wen        = ctl[0];
            mem_is_load    = ctl[1];
            wb_wen         = ctl[2];
            ex_rn          = W'(s);
            ex_rm          = W'((s + 1) % 8);
            ex_rt          = W'((s + 3) % 8);
            mem_sets_flags = ctl[0] ^ s[0];
            wb_sets_flags  = s[1];
            @(negedge clk);
            check(tag_for(ex_rn), sel_rn, expect_sel(ex_rn));
            check({"R11/", tag_for(ex_rm)}, sel_rm, expect_sel(ex_rm));
            check({"R8/", tag_for(ex_rt)}, sel_rt, expect_sel(ex_rt));
            check("R9", sel_flags,
                  mem_sets_flags ? 2'b01 : (wb_sets_flags ? 2'b10 : 2'b00));
          end
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule